// File: doc/BRIEF.md
# Carry-Sliced Pipelined Adder/Subtracter

This block adds or subtracts two wide unsigned operands through a pipeline whose depth is a parameter. The operands are cut into as many equal bit-slices as there are pipeline stages. The first stage sums every slice on its own and stores each partial sum with that slice's carry-out. Each later stage adds one stored carry into the slice above it. The carry therefore climbs one slice per clock until the top slice is complete. Slices that finished earlier are simply re-registered, so every bit of a result leaves in the same cycle.

Subtraction inverts B and feeds the carry input into the lowest slice. The carry input therefore acts as an active-low borrow-in, and the carry output as an active-low borrow-out. A load input routes B to the sum output with the same latency as arithmetic. A single clock enable qualifies every register, including the load path. With a latency of zero the block is a plain combinational adder. A new operand pair can be presented on every enabled cycle. Control pins are plain levels and there is no handshake: the caller pauses the stream with the clock enable.

Top module: `csa_pipe_addsub`

## Requirements
- R1: While `rst_n` is low, `sum_out` and `carry_out` are zero. The reset is asynchronous and also empties the pipeline.
- R2: With `op_add` = 1 and `load_b` = 0, `{carry_out, sum_out}` equals the (WIDTH+1)-bit unsigned sum `a_in + b_in + carry_in`.
- R3: With `op_add` = 0 and `load_b` = 0, the result is `a_in + ~b_in + carry_in` and `sum_out` holds its low WIDTH bits. `carry_in` = 1 means no borrow in; `carry_out` = 1 means no borrow out, and `carry_out` = 0 means the result went below zero.
- R4: A carry that has to cross every slice boundary (all-ones operands plus a carry) reaches the top bits and `carry_out` with the same latency as any other result.
- R5: After reset, the first LATENCY−1 enabled clock edges leave the outputs at zero. The result of the operands captured at the first enabled edge appears after the LATENCY-th enabled edge.
- R6: While `ce` is low, all pipeline state is frozen and the inputs are ignored. An operand pair captured before a stall leaves after exactly LATENCY enabled edges in total.
- R7: With `load_b` = 1, `sum_out` becomes `b_in` and `carry_out` becomes 0 after LATENCY enabled edges, whatever the values of `a_in`, `op_add` and `carry_in`.
- R8: `load_b` is qualified by `ce`. A load that is requested while `ce` is low leaves the outputs unchanged.
- R9: Operand pairs given on consecutive enabled edges produce their results on consecutive enabled edges, in the same order.
- R10: With LATENCY = 0 the block holds no registers, and the outputs follow R2, R3 and R7 in the same cycle as the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Clock enable for every pipeline register |
| op_add | input | 1 | 1 selects addition, 0 selects subtraction |
| carry_in | input | 1 | Carry in; active-low borrow in when subtracting |
| load_b | input | 1 | Route `b_in` to the output instead of the arithmetic result |
| a_in | input | WIDTH | Operand A |
| b_in | input | WIDTH | Operand B, also the load value |
| sum_out | output | WIDTH | Result |
| carry_out | output | 1 | Carry out; active-low borrow out when subtracting |

## Verification
Each registered result is due after LATENCY rising edges at which `ce` was high, counted from the edge that captured the operands. Edges with `ce` low do not count. The bench drives inputs and samples outputs on the falling edge, and the stream check compares the vector given LATENCY falling edges earlier. The stall and fill tests count only enabled edges and check the output after each one. A second instance with zero latency is checked 1 ns after each drive, because its result is due in the same cycle.

// File: rtl/csa_pkg.sv
`timescale 1ns/1ps
package csa_pkg;
  // Slice width: with at least one stage, the padded operand holds WIDTH+1 bits,
  // so the final carry lands in a padded bit instead of leaving the top slice.
  function automatic int slice_width(input int width, input int stages);
    return (stages == 0) ? width + 1 : (width + stages) / stages;
  endfunction
endpackage

// File: rtl/csa_operand_prep.sv
`timescale 1ns/1ps
module csa_operand_prep #(
  parameter int W  = 32,
  parameter int PW = 33
) (
  input  logic [W-1:0]  a_in,
  input  logic [W-1:0]  b_in,
  input  logic          op_add,
  input  logic          carry_in,
  input  logic          load_b,
  output logic [PW-1:0] a_pad,
  output logic [PW-1:0] b_pad,
  output logic          cin
);
  localparam int PADW = PW - W;

  logic [W-1:0] b_eff;

  // A load zeroes A and the carry, so B passes through the adders unchanged
  always_comb begin
    b_eff = (load_b || op_add) ? b_in : ~b_in;
    a_pad = load_b ? '0 : {{PADW{1'b0}}, a_in};
    b_pad = {{PADW{1'b0}}, b_eff};
    cin   = load_b ? 1'b0 : carry_in;
  end
endmodule

// File: rtl/csa_slice_add.sv
`timescale 1ns/1ps
module csa_slice_add #(
  parameter int SW = 8
) (
  input  logic [SW-1:0] x,
  input  logic [SW-1:0] y,
  input  logic          ci,
  output logic [SW-1:0] s,
  output logic          co
);
  assign {co, s} = {1'b0, x} + {1'b0, y} + {{SW{1'b0}}, ci};
endmodule

// File: rtl/csa_carry_pipe.sv
`timescale 1ns/1ps
module csa_carry_pipe #(
  parameter int PW     = 33,
  parameter int STAGES = 4,
  parameter int SW     = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic [PW-1:0] a_pad,
  input  logic [PW-1:0] b_pad,
  input  logic          cin,
  output logic [PW-1:0] res
);
  if (STAGES == 0) begin : g_comb
    assign res = a_pad + b_pad + {{(PW-1){1'b0}}, cin};
  end else begin : g_piped
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      logic [PW-1:0]     s_nx;
      logic [STAGES-1:0] c_nx;
      logic [PW-1:0]     q_s;
      logic [STAGES-1:0] q_c;

      for (genvar j = 0; j < STAGES; j++) begin : g_slice
        if (k == 0) begin : g_first
          // Stage one: every slice sums on its own; only slice 0 sees the carry in
          if (j == 0) begin : g_lsb
            csa_slice_add #(.SW(SW)) u_add (
              .x(a_pad[j*SW +: SW]), .y(b_pad[j*SW +: SW]), .ci(cin),
              .s(s_nx[j*SW +: SW]), .co(c_nx[j]));
          end else begin : g_upper
            csa_slice_add #(.SW(SW)) u_add (
              .x(a_pad[j*SW +: SW]), .y(b_pad[j*SW +: SW]), .ci(1'b0),
              .s(s_nx[j*SW +: SW]), .co(c_nx[j]));
          end
        end else if (j == k) begin : g_resolve
          // Stage k folds the stored carry of slice k-1 into slice k
          logic co_k;
          csa_slice_add #(.SW(SW)) u_add (
            .x(g_stage[k-1].q_s[j*SW +: SW]), .y({SW{1'b0}}),
            .ci(g_stage[k-1].q_c[j-1]),
            .s(s_nx[j*SW +: SW]), .co(co_k));
          // A slice cannot carry in both stages, so the two carries merge with OR
          assign c_nx[j] = g_stage[k-1].q_c[j] | co_k;
        end else begin : g_hold
          assign s_nx[j*SW +: SW] = g_stage[k-1].q_s[j*SW +: SW];
          assign c_nx[j]          = g_stage[k-1].q_c[j];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_s <= '0;
          q_c <= '0;
        end else if (ce) begin
          q_s <= s_nx;
          q_c <= c_nx;
        end
      end
    end

    assign res = g_stage[STAGES-1].q_s;

    logic unused_last_carries;
    assign unused_last_carries = ^g_stage[STAGES-1].q_c;
  end
endmodule

// File: rtl/csa_pipe_addsub.sv
`timescale 1ns/1ps
module csa_pipe_addsub #(
  parameter int WIDTH   = 32,
  parameter int LATENCY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             op_add,
  input  logic             carry_in,
  input  logic             load_b,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);
  localparam int SW = csa_pkg::slice_width(WIDTH, LATENCY);
  localparam int PW = (LATENCY == 0) ? WIDTH + 1 : SW * LATENCY;

  if (LATENCY < 0 || LATENCY > WIDTH || LATENCY > 64) begin : g_bad_latency
    $error("csa_pipe_addsub: LATENCY must lie in 0..min(WIDTH,64)");
  end

  logic [PW-1:0] a_pad;
  logic [PW-1:0] b_pad;
  logic          cin;
  logic [PW-1:0] res_pad;

  csa_operand_prep #(.W(WIDTH), .PW(PW)) u_prep (
    .a_in(a_in), .b_in(b_in), .op_add(op_add), .carry_in(carry_in),
    .load_b(load_b), .a_pad(a_pad), .b_pad(b_pad), .cin(cin));

  csa_carry_pipe #(.PW(PW), .STAGES(LATENCY), .SW(SW)) u_pipe (
    .clk(clk), .rst_n(rst_n), .ce(ce), .a_pad(a_pad), .b_pad(b_pad),
    .cin(cin), .res(res_pad));

  // Bit WIDTH of the padded result is the carry out; the bits above it stay zero
  assign sum_out   = res_pad[WIDTH-1:0];
  assign carry_out = res_pad[WIDTH];

  logic unused_pad_bits;
  assign unused_pad_bits = ^res_pad;
endmodule

// File: rtl/csa_pipe_checker.sv
`timescale 1ns/1ps
module csa_pipe_checker #(
  parameter int WIDTH   = 32,
  parameter int LATENCY = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce,
  input logic             op_add,
  input logic             carry_in,
  input logic             load_b,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] sum_out,
  input logic             carry_out
);
  logic [WIDTH:0] want_now;

  always_comb begin
    if (load_b) want_now = {1'b0, b_in};
    else want_now = {1'b0, a_in} + {1'b0, (op_add ? b_in : ~b_in)}
                    + {{WIDTH{1'b0}}, carry_in};
  end

  if (LATENCY == 0) begin : g_chk_comb
    always @(posedge clk) begin
      if (rst_n) begin
        a_r10_same_cycle: assert ({carry_out, sum_out} == want_now)
          else $error("R10 combinational result mismatch");
      end
    end
  end else begin : g_chk_piped
    localparam int FW = $clog2(LATENCY + 1);
    localparam logic [FW-1:0] FULL = FW'(LATENCY);

    logic [WIDTH:0] mdl [LATENCY];
    logic [FW-1:0]  fill;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < LATENCY; i++) mdl[i] <= '0;
        fill <= '0;
      end else if (ce) begin
        mdl[0] <= want_now;
        for (int i = 1; i < LATENCY; i++) mdl[i] <= mdl[i-1];
        if (fill != FULL) fill <= fill + FW'(1);
      end
    end

    always @(posedge clk) begin
      if (!rst_n) begin
        a_r1_reset_zero: assert (sum_out == '0 && carry_out == 1'b0)
          else $error("R1 output not zero in reset");
      end
    end

    // R2 R3 R7 R9: result equals the operands captured LATENCY enabled edges ago
    a_r2_result_due: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == FULL) |-> ({carry_out, sum_out} == mdl[LATENCY-1]))
      else $error("R2 result mismatch");

    a_r5_fill_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (fill != FULL) |-> (sum_out == '0 && carry_out == 1'b0))
      else $error("R5 output not zero while filling");

    // R6 R8: a disabled edge changes nothing
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> ($stable(sum_out) && $stable(carry_out)))
      else $error("R6 output moved during stall");
  end
endmodule

bind csa_pipe_addsub csa_pipe_checker #(.WIDTH(WIDTH), .LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .op_add(op_add), .carry_in(carry_in),
  .load_b(load_b), .a_in(a_in), .b_in(b_in), .sum_out(sum_out),
  .carry_out(carry_out));

// File: tb/sim_csa_pipe_addsub.sv
`timescale 1ns/1ps
module sim_csa_pipe_addsub;
  localparam int W   = 16;
  localparam int LAT = 4;
  localparam int NV  = 12;

  // {op_add, carry_in, load_b, a, b, expected carry, expected sum}
  localparam logic [51:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 16'h1234, 16'h0101, 1'b0, 16'h1335},
    {1'b1, 1'b0, 1'b0, 16'hFFFF, 16'h0001, 1'b1, 16'h0000},
    {1'b1, 1'b1, 1'b0, 16'hFFFF, 16'h0000, 1'b1, 16'h0000},
    {1'b1, 1'b1, 1'b0, 16'h8000, 16'h8000, 1'b1, 16'h0001},
    {1'b0, 1'b1, 1'b0, 16'h0005, 16'h0003, 1'b1, 16'h0002},
    {1'b0, 1'b1, 1'b0, 16'h0003, 16'h0005, 1'b0, 16'hFFFE},
    {1'b0, 1'b0, 1'b0, 16'h1000, 16'h0001, 1'b1, 16'h0FFE},
    {1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0000},
    {1'b1, 1'b1, 1'b1, 16'hFFFF, 16'hABCD, 1'b0, 16'hABCD},
    {1'b0, 1'b0, 1'b1, 16'h1111, 16'h5A5A, 1'b0, 16'h5A5A},
    {1'b1, 1'b1, 1'b0, 16'h7FFF, 16'h7FFF, 1'b0, 16'hFFFF},
    {1'b1, 1'b0, 1'b0, 16'h00F0, 16'h0F10, 1'b0, 16'h1000}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         ce;
  logic         op_add;
  logic         carry_in;
  logic         load_b;
  logic [W-1:0] a_in;
  logic [W-1:0] b_in;
  logic [W-1:0] s0;
  logic         c0;
  logic [W-1:0] s1;
  logic         c1;
  int           checks = 0;
  int           errors = 0;

  always #2 clk = ~clk;

  csa_pipe_addsub #(.WIDTH(W), .LATENCY(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .ce(ce), .op_add(op_add), .carry_in(carry_in),
    .load_b(load_b), .a_in(a_in), .b_in(b_in), .sum_out(s0), .carry_out(c0));

  csa_pipe_addsub #(.WIDTH(W), .LATENCY(0)) u1 (
    .clk(clk), .rst_n(rst_n), .ce(ce), .op_add(op_add), .carry_in(carry_in),
    .load_b(load_b), .a_in(a_in), .b_in(b_in), .sum_out(s1), .carry_out(c1));

  task automatic check(input string tag, input logic [W:0] got, input logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic add, input logic ci, input logic ld,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    op_add = add; carry_in = ci; load_b = ld; a_in = a; b_in = b;
  endtask

  function automatic string vec_tag(input int idx);
    if (VEC[idx][49]) return "R7";
    if (idx == 1 || idx == 2) return "R4";
    return VEC[idx][51] ? "R2" : "R3";
  endfunction

  initial begin
    rst_n = 1'b0;
    ce    = 1'b1;
    drive(1'b1, 1'b1, 1'b0, 16'hFFFF, 16'h0001);
    repeat (3) @(negedge clk);
    check("R1 reset holds outputs at zero", {c0, s0}, 17'h0);
    rst_n = 1'b1;

    // R5: fill after reset
    drive(1'b1, 1'b0, 1'b0, 16'h1234, 16'h0101);
    for (int k = 1; k <= LAT; k++) begin
      @(negedge clk);
      if (k < LAT) check("R5 zero during fill", {c0, s0}, 17'h0);
      else         check("R5 first result after LATENCY edges", {c0, s0}, {1'b0, 16'h1335});
    end

    // R6 R8: stall with a load request, which must be ignored
    ce = 1'b0;
    drive(1'b1, 1'b1, 1'b1, 16'hFFFF, 16'hDEAD);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R8 load ignored while ce low", {c0, s0}, {1'b0, 16'h1335});
    end

    // R6: operand captured, then a stall in flight
    ce = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 16'h00F0, 16'h0F10);
    @(negedge clk);
    ce = 1'b0;
    drive(1'b0, 1'b1, 1'b0, 16'hFFFF, 16'hFFFF);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R6 frozen during stall", {c0, s0}, {1'b0, 16'h1335});
    end
    ce = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 16'h1234, 16'h0101);
    for (int k = 0; k < LAT - 2; k++) begin
      @(negedge clk);
      check("R6 older result until due", {c0, s0}, {1'b0, 16'h1335});
    end
    @(negedge clk);
    check("R6 stalled operand after LATENCY enabled edges", {c0, s0}, {1'b0, 16'h1000});

    // R9: back-to-back stream through the vector table; R10 on the zero-latency instance
    for (int i = 0; i < NV + LAT; i++) begin
      if (i >= LAT)
        check($sformatf("%s/R9 stream vector %0d", vec_tag(i - LAT), i - LAT),
              {c0, s0}, VEC[i-LAT][16:0]);
      if (i < NV) begin
        drive(VEC[i][51], VEC[i][50], VEC[i][49], VEC[i][48:33], VEC[i][32:17]);
        #1;
        check($sformatf("R10 same-cycle vector %0d", i), {c1, s1}, VEC[i][16:0]);
      end else begin
        drive(1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000);
      end
      @(negedge clk);
    end

    // R1: asynchronous reset in mid-stream
    drive(1'b1, 1'b0, 1'b0, 16'h4321, 16'h1111);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 check("R1 asynchronous clear", {c0, s0}, 17'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1/R5 pipeline emptied by reset", {c0, s0}, 17'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired got hang expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule